// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block is the slave side of a byte-wide processor bus. A host reaches a small internal register file through a 12-bit address and an 8-bit data path. The block serves two bus styles on one set of pins, and a static `bus_mode` input picks the style:

- **Style 0** uses an address strobe, a data strobe and a read/write direction level. It answers with an active-low data-acknowledge.
- **Style 1** uses an active-low address latch enable and separate active-low read and write strobes. It answers with an active-high ready.

Chip select and the data path are common to both styles. The tristate pad buffer sits outside the block and is controlled by `d_oe`.

The register file holds four kinds of register:

- a configuration register, one bit of which inverts the interrupt pin;
- an interrupt enable register;
- a pending-status register, set by event inputs and cleared by the host;
- a few scratch registers for test.

The interrupt pin carries the OR of the enabled pending bits, passed through the polarity selection. All pins are sampled on `clk`, the processor clock. The style 0 acknowledge is formed combinationally from the pins, so it does not depend on that clock.

Top module: `host_bus_if`

## Requirements
- R1: While `addr_stb_n` is low, the address is captured on every clock. It is held unchanged once `addr_stb_n` is high. Every access uses this held address, whatever `addr` does later.
- R2: Style 0 read (`bus_mode`=0). With `cs_n`=0, `stb1`=1 (1 means read) and `stb0_n`=0, the block drives `d_oe`=1 and puts the addressed register on `d_o`, combinationally.
- R3: Style 0 write. With `cs_n`=0, `stb1`=0 (0 means write) and `stb0_n` low, `d_i` is captured. The write takes effect at the clock edge that first sees `stb0_n` or `cs_n` go high.
- R4: Style 1 (`bus_mode`=1). `stb1` is an active-low read strobe and drives `d_o`/`d_oe` as in R2. `stb0_n` is an active-low write strobe and commits as in R3.
- R5: In style 0, `ack` is an active-low acknowledge. It is 0 exactly while `cs_n` and `stb0_n` are both low, combinationally, and 1 otherwise.
- R6: In style 1, `ack` is an active-high ready. It is 1 in the cycle after a clock edge that sees `cs_n`=0 together with a low read or write strobe, and 0 otherwise.
- R7: `d_oe` is 0 whenever `cs_n` is high or no read strobe is active, including during writes.
- R8: Strobes with `cs_n` high change no register and do not drive the data path.
- R9: The register map is as follows:
  - address 0x000: configuration;
  - address 0x001: interrupt enable;
  - address 0x002: pending status. Writing 1 to a bit clears it, and each clock `evt` sets the bits that are high. A set wins over a clear in the same cycle.
  - addresses 0x003 to NREG-1: read/write scratch registers;
  - all other addresses: read as 0x00, and writes to them are dropped.
- R10: `irq` is the OR of the pending bits ANDed with the enable bits. It is active-high when configuration bit 6 is 0, and inverted when that bit is 1.
- R11: After reset, all registers are 0, `irq`=0 and `d_oe`=0. `ack` is 1 in style 0 and 0 in style 1 while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 1 | Static style select: 0 = strobe plus direction, 1 = separate read/write strobes |
| cs_n | input | 1 | Chip select, active-low |
| addr_stb_n | input | 1 | Address strobe (style 0) or address latch enable (style 1), active-low |
| stb0_n | input | 1 | Data strobe (style 0) or write strobe (style 1), active-low |
| stb1 | input | 1 | Direction level, 1 = read (style 0), or read strobe, active-low (style 1) |
| addr | input | 12 | Address bus |
| d_i | input | 8 | Data from the pad (host write data) |
| d_o | output | 8 | Data to the pad (read data) |
| d_oe | output | 1 | Pad output enable for the data bus |
| ack | output | 1 | Data-acknowledge, active-low (style 0), or ready, active-high (style 1) |
| evt | input | 8 | Status events; a high bit sets the matching pending bit |
| irq | output | 1 | Interrupt request with programmable polarity |

## Verification
The assertions assume that `bus_mode` changes only while reset is held. They also assume that in style 0 the direction level `stb1` stays steady while `stb0_n` is low, so a change of direction is never mistaken for the end of a write. In both styles, the address strobe must close before the data strobe opens. The bench changes the style only under reset, sets direction and address one clock before the data strobe, and keeps `stb1` fixed until the strobe and chip select are released. It also drives `addr` with unrelated values after the latch closes, which exercises the hold in R1.

// File: rtl/host_bus_if.sv
module host_bus_if #(
  parameter int AW          = 12,
  parameter int DW          = 8,
  parameter int NREG        = 8,
  parameter int IRQ_POL_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_mode,
  input  logic          cs_n,
  input  logic          addr_stb_n,
  input  logic          stb0_n,
  input  logic          stb1,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] d_o,
  output logic          d_oe,
  output logic          ack,
  input  logic [DW-1:0] evt,
  output logic          irq
);

  localparam logic [AW-1:0] A_CFG  = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_PEND = AW'(2);
  localparam int            FIRST_SCR = 3;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, cfg_q, en_q, pend_q, rdata;
  logic [DW-1:0] scr_q [FIRST_SCR:NREG-1];
  logic          wr_q, rdy_q, cs_q;
  logic          rd_act, wr_act, commit;

  assign rd_act = !cs_n && (bus_mode ? !stb1 : (!stb0_n && stb1));
  assign wr_act = !cs_n && !stb0_n && (bus_mode || !stb1);
  assign commit = wr_q && !wr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rdy_q   <= 1'b0;
      cs_q    <= 1'b1;
      cfg_q   <= '0;
      en_q    <= '0;
      pend_q  <= '0;
    end else begin
      if (!addr_stb_n) addr_q <= addr;
      if (wr_act) wdata_q <= d_i;
      wr_q  <= wr_act;
      rdy_q <= rd_act || wr_act;
      cs_q  <= cs_n;
      if (commit && addr_q == A_CFG) cfg_q <= wdata_q;
      if (commit && addr_q == A_EN)  en_q  <= wdata_q;
      pend_q <= (pend_q & ~((commit && addr_q == A_PEND) ? wdata_q : '0)) | evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = FIRST_SCR; i < NREG; i++) scr_q[i] <= '0;
    end else begin
      for (int i = FIRST_SCR; i < NREG; i++)
        if (commit && addr_q == AW'(i)) scr_q[i] <= wdata_q;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr_q == A_CFG)  rdata = cfg_q;
    if (addr_q == A_EN)   rdata = en_q;
    if (addr_q == A_PEND) rdata = pend_q;
    for (int i = FIRST_SCR; i < NREG; i++)
      if (addr_q == AW'(i)) rdata = scr_q[i];
  end

  assign d_o  = rdata;
  assign d_oe = rd_act;
  assign ack  = bus_mode ? rdy_q : (cs_n || stb0_n);
  assign irq  = (|(pend_q & en_q)) ^ cfg_q[IRQ_POL_BIT];

  // R1: the held address moves only in a cycle that followed a low strobe
  a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(addr_stb_n) |-> $stable(addr_q));

  // R5: acknowledge low while selected data strobe is low
  a_r5_dtack_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_mode && !cs_n && !stb0_n) |-> !ack);

  // R6: ready follows a selected strobe by one clock
  a_r6_rdy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode && !cs_n && (!stb0_n || !stb1)) |=> ack);

  // R7: the data path is driven only while selected
  a_r7_oe_selected: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> !cs_n);

  // R8: no register change after a cycle without chip select
  a_r8_no_cs_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> ($stable(cfg_q) && $stable(en_q)));

  // R10: with nothing enabled and pending, the pin rests at its idle level
  a_r10_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend_q & en_q)) |-> (irq == cfg_q[IRQ_POL_BIT]));

endmodule

// File: tb/test_host_bus_if.sv
module test_host_bus_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_mode = 1'b0;
  logic        cs_n = 1'b1, addr_stb_n = 1'b1, stb0_n = 1'b1, stb1 = 1'b1;
  logic [11:0] addr = '0;
  logic [7:0]  d_i = '0, evt = '0;
  logic [7:0]  d_o;
  logic        d_oe, ack, irq;

  int nchk = 0, nfail = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  logic rdy_e = 1'b0;
  logic [7:0] m_cfg, m_en, m_pend;
  logic [7:0] m_scr [0:7];

  always #4 clk = ~clk;

  host_bus_if i_host_bus_if (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n),
    .addr_stb_n(addr_stb_n), .stb0_n(stb0_n), .stb1(stb1), .addr(addr),
    .d_i(d_i), .d_o(d_o), .d_oe(d_oe), .ack(ack), .evt(evt), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [11:0] a);
    case (a)
      12'h000: return m_cfg;
      12'h001: return m_en;
      12'h002: return m_pend;
      12'h003, 12'h004, 12'h005, 12'h006, 12'h007: return m_scr[a[2:0]];
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_write(input logic [11:0] a, input logic [7:0] v, input logic [7:0] e);
    case (a)
      12'h000: m_cfg = v;
      12'h001: m_en = v;
      12'h002: m_pend = m_pend & ~v;
      12'h003, 12'h004, 12'h005, 12'h006, 12'h007: m_scr[a[2:0]] = v;
      default: ;
    endcase
    m_pend = m_pend | e;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0;
    mon_on = 1'b0;
    bus_mode = mode;
    m_cfg = '0; m_en = '0; m_pend = '0;
    for (int i = 0; i < 8; i++) m_scr[i] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [7:0] v, input bit sel, input logic [7:0] e);
    @(negedge clk);
    addr = a; addr_stb_n = 1'b0; cs_n = !sel; stb1 = bus_mode;
    @(negedge clk);
    addr_stb_n = 1'b1; addr = ~a; d_i = v; stb0_n = 1'b0;
    #1 chk(d_oe == 1'b0, "R7 oe during write", d_oe, 0);
    @(negedge clk);
    stb0_n = 1'b1; evt = e;
    if (sel) m_write(a, v, e); else m_pend = m_pend | e;
    @(negedge clk);
    cs_n = 1'b1; d_i = '0; evt = '0; stb1 = 1'b1;
  endtask

  task automatic bus_read(input logic [11:0] a, input bit sel, input string req);
    @(negedge clk);
    addr = a; addr_stb_n = 1'b0; cs_n = !sel; stb1 = 1'b1;
    @(negedge clk);
    addr_stb_n = 1'b1; addr = ~a;
    if (bus_mode) stb1 = 1'b0; else stb0_n = 1'b0;
    #1;
    if (sel) begin
      chk(d_oe == 1'b1, req, d_oe, 1);
      chk(d_o == m_read(a), req, d_o, m_read(a));
    end else begin
      chk(d_oe == 1'b0, {req, " unselected oe"}, d_oe, 0);
    end
    @(negedge clk);
    stb0_n = 1'b1; stb1 = 1'b1;
    #1 chk(d_oe == 1'b0, "R7 oe after strobe", d_oe, 0);
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic pulse_evt(input logic [7:0] e);
    @(negedge clk);
    evt = e; m_pend = m_pend | e;
    @(negedge clk);
    evt = '0;
  endtask

  always @(posedge clk) begin
    rdy_e = !cs_n && (!stb0_n || !stb1);
    #2;
    if (rst_n && mon_on) begin
      if (bus_mode) chk(ack == rdy_e, "R6 ready", ack, rdy_e);
      else          chk(ack == (cs_n || stb0_n), "R5 acknowledge", ack, cs_n || stb0_n);
      chk(irq == ((|(m_pend & m_en)) ^ m_cfg[6]), "R10 irq", irq, (|(m_pend & m_en)) ^ m_cfg[6]);
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    @(negedge clk);
    chk(irq == 1'b0 && d_oe == 1'b0 && ack == 1'b1, "R11 reset outputs", {irq, d_oe, ack}, 3'b001);
    for (int a = 0; a < 8; a++) bus_read(12'(a), 1'b1, "R11 reset value");

    // style 0 writes and reads
    bus_write(12'h003, 8'hA5, 1'b1, 8'h00);
    bus_write(12'h004, 8'h5A, 1'b1, 8'h00);
    bus_write(12'h007, 8'hFF, 1'b1, 8'h00);
    bus_read(12'h003, 1'b1, "R3 R2 R1 scratch 3");
    bus_read(12'h004, 1'b1, "R3 R2 scratch 4");
    bus_read(12'h007, 1'b1, "R3 R2 scratch 7");

    // unmapped addresses
    bus_write(12'h800, 8'h77, 1'b1, 8'h00);
    bus_write(12'h008, 8'h66, 1'b1, 8'h00);
    bus_read(12'h800, 1'b1, "R9 unmapped read");
    bus_read(12'hFFF, 1'b1, "R9 unmapped read top");
    bus_read(12'h003, 1'b1, "R9 unmapped write aliasing");

    // chip select high
    bus_write(12'h003, 8'h11, 1'b0, 8'h00);
    bus_write(12'h001, 8'hFF, 1'b0, 8'h00);
    bus_read(12'h003, 1'b0, "R8 R7 read unselected");
    bus_read(12'h003, 1'b1, "R8 write unselected");
    bus_read(12'h001, 1'b1, "R8 enable untouched");

    // interrupts, pending, polarity
    pulse_evt(8'h05);
    bus_read(12'h002, 1'b1, "R9 pending set by event");
    bus_write(12'h001, 8'h04, 1'b1, 8'h00);
    @(negedge clk);
    chk(irq == 1'b1, "R10 irq active-high", irq, 1);
    bus_write(12'h000, 8'h40, 1'b1, 8'h00);
    @(negedge clk);
    chk(irq == 1'b0, "R10 irq inverted", irq, 0);
    bus_write(12'h002, 8'h04, 1'b1, 8'h00);
    @(negedge clk);
    chk(irq == 1'b1, "R10 R9 cleared idles high when inverted", irq, 1);
    bus_read(12'h002, 1'b1, "R9 write-one-to-clear");
    bus_write(12'h002, 8'h01, 1'b1, 8'h01);
    bus_read(12'h002, 1'b1, "R9 set wins over clear");
    bus_write(12'h000, 8'h00, 1'b1, 8'h00);
    bus_read(12'h000, 1'b1, "R9 configuration");

    // style 1
    do_reset(1'b1);
    @(negedge clk);
    chk(ack == 1'b0 && d_oe == 1'b0 && irq == 1'b0, "R11 R6 idle style 1", {ack, d_oe, irq}, 3'b000);
    bus_write(12'h005, 8'h3C, 1'b1, 8'h00);
    bus_write(12'h006, 8'hC3, 1'b1, 8'h00);
    bus_read(12'h005, 1'b1, "R4 R1 style 1 read 5");
    bus_read(12'h006, 1'b1, "R4 style 1 read 6");
    bus_write(12'h006, 8'h00, 1'b0, 8'h00);
    bus_read(12'h006, 1'b1, "R8 R4 style 1 unselected write");
    bus_write(12'h001, 8'h80, 1'b1, 8'h00);
    pulse_evt(8'h80);
    @(negedge clk);
    chk(irq == 1'b1, "R10 R4 style 1 irq", irq, 1);
    bus_write(12'h002, 8'h80, 1'b1, 8'h00);
    @(negedge clk);
    chk(irq == 1'b0, "R10 R9 style 1 clear", irq, 0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule